// File: doc/BRIEF.md
# Remote Terminal Command Acceptance Filter

This block sits behind the word decoder of a serial-bus remote terminal and decides, for each received command word, whether the terminal acts on it. For each strobed command it reports the following, one clock after the strobe:

- whether the command is legal to execute;
- whether it was sent to the shared all-terminals address;
- whether a status reply is due;
- whether the last-command and status record should be refreshed.

A second output continuously flags a failed parity check on the terminal's own strapped address.

Several inputs shape the decision:

- The terminal works only while the run bit is set and its own address passes an odd parity check.
- A configuration bit chooses whether address 31 is a broadcast address or is ignored as if no terminal owned it.
- A second configuration bit makes the standard undefined mode codes illegal.
- An external illegalization lookup result can mark any single command illegal.

Top module: `rt_cmd_filter`

## Requirements
- R1: After reset all outputs are 0. The outputs `cmd_accept`, `cmd_bcast`, `cmd_respond` and `cmd_upd_last` are registered. They reflect the inputs sampled at the clock edge where `cmd_valid` is 1, and are 0 after any edge where `cmd_valid` is 0.
- R2: While `run_en` is 0, no command is recognised and all four command outputs stay 0.
- R3: Own-address parity is odd: the count of ones in `{own_addr, own_addr_par}` must be odd. If it is even, `addr_par_fail` is 1 from the next edge onward and no command is recognised, whatever `run_en` is.
- R4: A recognised command to the terminal's own address (not 31) gives `cmd_respond`=1, `cmd_upd_last`=1 and `cmd_bcast`=0.
- R5: With `bcast_off`=0, a recognised command to address 31 gives `cmd_bcast`=1, `cmd_upd_last`=1 and `cmd_respond`=0.
- R6: With `bcast_off`=1, a command to address 31 is not recognised, so all four command outputs are 0 (no reply, no record update).
- R7: A command to any address other than the own address and 31 gives all four command outputs 0.
- R8: A command is a mode command when `cmd_subaddr` is 0 or 31, and `cmd_wc_mc` is then the mode code. The undefined mode codes are:
  - with `cmd_tr`=0: codes 0–16, 18 and 19;
  - with `cmd_tr`=1: codes 17, 20 and 21.
- R9: With `undef_mc_off`=0, an undefined mode code is judged by `illegal_hit` alone: `cmd_accept` = recognised and not `illegal_hit`.
- R10: With `undef_mc_off`=1, a recognised undefined mode code gives `cmd_accept`=0 even when `illegal_hit`=0. `cmd_respond` and `cmd_upd_last` still follow R4/R5.
- R11: `illegal_hit`=1 on a recognised command gives `cmd_accept`=0. A defined mode code or a data command (subaddress 1–30) is never made illegal by `undef_mc_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe: a decoded command word is present |
| cmd_rt_addr | input | 5 | Addressed terminal field of the command |
| cmd_tr | input | 1 | Transmit (1) / receive (0) bit |
| cmd_subaddr | input | 5 | Subaddress field; 0 or 31 means mode command |
| cmd_wc_mc | input | 5 | Word count, or mode code for mode commands |
| own_addr | input | 5 | Terminal's strapped address |
| own_addr_par | input | 1 | Strapped address parity bit (odd) |
| run_en | input | 1 | Run enable |
| bcast_off | input | 1 | 1: address 31 is ignored; 0: address 31 is broadcast |
| undef_mc_off | input | 1 | 1: undefined mode codes are illegal |
| illegal_hit | input | 1 | Illegalization lookup says this command is illegal |
| cmd_accept | output | 1 | Command is recognised and legal |
| cmd_bcast | output | 1 | Command recognised as broadcast |
| cmd_respond | output | 1 | A status reply is due |
| cmd_upd_last | output | 1 | Refresh the last-command and status record |
| addr_par_fail | output | 1 | Own-address parity check failed |

## Verification
A broadcast command can also carry an undefined mode code while undefined codes are switched off. In that cycle the broadcast path must set `cmd_bcast` and `cmd_upd_last`, and the legality path must drop `cmd_accept`. The bench provokes this directly with a receive-direction code 5 to address 31. It also reaches it in the random phase, where the command address is biased toward 31 and the own address, and both configuration bits toggle. A behavioural model in the bench predicts all five outputs for every cycle from the previous cycle's inputs, and any output that differs is reported under its requirement.

// File: rtl/rt_cmd_filter_pkg.sv
package rt_cmd_filter_pkg;

    localparam int ADDR_W = 5;
    localparam int SA_W   = 5;
    localparam int MC_W   = 5;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;
    localparam logic [SA_W-1:0]   MODE_SA_LO = '0;
    localparam logic [SA_W-1:0]   MODE_SA_HI = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] rt_addr;
        logic              tr;
        logic [SA_W-1:0]   subaddr;
        logic [MC_W-1:0]   wc_mc;
    } cmd_word_t;

    typedef enum logic [1:0] {
        DEST_NONE  = 2'd0,
        DEST_OWN   = 2'd1,
        DEST_BCAST = 2'd2
    } dest_e;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic respond;
        logic upd_last;
    } verdict_t;

    // Receive-direction undefined set: 0..16, 18, 19
    function automatic logic undef_rx(input logic [MC_W-1:0] code);
        return (code <= 5'd16) || (code == 5'd18) || (code == 5'd19);
    endfunction

    // Transmit-direction undefined set: 17, 20, 21
    function automatic logic undef_tx(input logic [MC_W-1:0] code);
        return (code == 5'd17) || (code == 5'd20) || (code == 5'd21);
    endfunction

endpackage

// File: rtl/rt_own_addr_check.sv
module rt_own_addr_check
    import rt_cmd_filter_pkg::*;
(
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              own_addr_par,
    input  logic              run_en,
    output logic              par_ok,
    output logic              active
);
    always_comb begin
        par_ok = ^{own_addr, own_addr_par};
        active = run_en && par_ok;
    end
endmodule

// File: rtl/rt_mode_decode.sv
module rt_mode_decode
    import rt_cmd_filter_pkg::*;
(
    input  cmd_word_t cmd,
    output logic      is_mode,
    output logic      is_undef
);
    always_comb begin
        is_mode  = (cmd.subaddr == MODE_SA_LO) || (cmd.subaddr == MODE_SA_HI);
        is_undef = is_mode && (cmd.tr ? undef_tx(cmd.wc_mc) : undef_rx(cmd.wc_mc));
    end
endmodule

// File: rtl/rt_dest_select.sv
module rt_dest_select
    import rt_cmd_filter_pkg::*;
(
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_off,
    output dest_e             dest
);
    always_comb begin
        if (rt_addr == BCAST_ADDR)
            dest = bcast_off ? DEST_NONE : DEST_BCAST;
        else if (rt_addr == own_addr)
            dest = DEST_OWN;
        else
            dest = DEST_NONE;
    end
endmodule

// File: rtl/rt_cmd_filter.sv
module rt_cmd_filter
    import rt_cmd_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [4:0] cmd_rt_addr,
    input  logic       cmd_tr,
    input  logic [4:0] cmd_subaddr,
    input  logic [4:0] cmd_wc_mc,
    input  logic [4:0] own_addr,
    input  logic       own_addr_par,
    input  logic       run_en,
    input  logic       bcast_off,
    input  logic       undef_mc_off,
    input  logic       illegal_hit,
    output logic       cmd_accept,
    output logic       cmd_bcast,
    output logic       cmd_respond,
    output logic       cmd_upd_last,
    output logic       addr_par_fail
);
    cmd_word_t cmd;
    logic      par_ok, active, is_mode, is_undef, recog, illegal;
    dest_e     dest;
    verdict_t  nxt, q;
    logic      par_fail_q;

    assign cmd = '{rt_addr: cmd_rt_addr, tr: cmd_tr, subaddr: cmd_subaddr, wc_mc: cmd_wc_mc};

    rt_own_addr_check u_addr_chk (
        .own_addr    (own_addr),
        .own_addr_par(own_addr_par),
        .run_en      (run_en),
        .par_ok      (par_ok),
        .active      (active)
    );

    rt_mode_decode u_mode (
        .cmd     (cmd),
        .is_mode (is_mode),
        .is_undef(is_undef)
    );

    rt_dest_select u_dest (
        .rt_addr  (cmd.rt_addr),
        .own_addr (own_addr),
        .bcast_off(bcast_off),
        .dest     (dest)
    );

    always_comb begin
        recog        = cmd_valid && active && (dest != DEST_NONE);
        illegal      = illegal_hit || (undef_mc_off && is_undef);
        nxt.accept   = recog && !illegal;
        nxt.bcast    = recog && (dest == DEST_BCAST);
        nxt.respond  = recog && (dest == DEST_OWN);
        nxt.upd_last = recog;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= '0;
            par_fail_q <= 1'b0;
        end else begin
            q          <= nxt;
            par_fail_q <= !par_ok;
        end
    end

    assign cmd_accept    = q.accept;
    assign cmd_bcast     = q.bcast;
    assign cmd_respond   = q.respond;
    assign cmd_upd_last  = q.upd_last;
    assign addr_par_fail = par_fail_q;

    // A broadcast never gets a status reply
    assert_bcast_silent_R5: assert property (@(posedge clk) disable iff (rst)
        !(cmd_bcast && cmd_respond));

    // Nothing issued when no strobe preceded
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !(cmd_accept || cmd_bcast || cmd_respond || cmd_upd_last));

    // Stopped terminal stays silent
    assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !(cmd_upd_last || cmd_respond));

    // Failed parity flag and any activity are exclusive
    assert_par_block_R3: assert property (@(posedge clk) disable iff (rst)
        addr_par_fail |-> !(cmd_upd_last || cmd_accept));

    // Ignored address 31 touches nothing
    assert_bcast_off_R6: assert property (@(posedge clk) disable iff (rst)
        (bcast_off && cmd_rt_addr == 5'd31) |=> !cmd_upd_last);

    // An acceptance always implies a record update
    assert_accept_recog_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> cmd_upd_last);
endmodule

// File: tb/rt_cmd_filter_tb.sv
module rt_cmd_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [4:0] cmd_rt_addr, cmd_subaddr, cmd_wc_mc, own_addr;
    logic       cmd_tr, own_addr_par, run_en, bcast_off, undef_mc_off, illegal_hit;
    logic       cmd_accept, cmd_bcast, cmd_respond, cmd_upd_last, addr_par_fail;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    bit e_acc, e_bc, e_rsp, e_upd, e_pf;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_cmd_filter u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rt_addr(cmd_rt_addr),
        .cmd_tr(cmd_tr), .cmd_subaddr(cmd_subaddr), .cmd_wc_mc(cmd_wc_mc),
        .own_addr(own_addr), .own_addr_par(own_addr_par), .run_en(run_en),
        .bcast_off(bcast_off), .undef_mc_off(undef_mc_off), .illegal_hit(illegal_hit),
        .cmd_accept(cmd_accept), .cmd_bcast(cmd_bcast), .cmd_respond(cmd_respond),
        .cmd_upd_last(cmd_upd_last), .addr_par_fail(addr_par_fail)
    );

    function automatic bit undefined_code(input bit tr, input int code);
        if (!tr) return (code < 16) || code == 16 || code == 18 || code == 19;
        return code == 17 || code == 20 || code == 21;
    endfunction

    // Behavioural reference: expected outputs after the next edge
    task automatic predict();
        int  ones = $countones({own_addr, own_addr_par});
        bit  good_par = (ones % 2) == 1;
        bit  to_bc  = (cmd_rt_addr == 31) && !bcast_off;
        bit  to_own = (cmd_rt_addr != 31) && (cmd_rt_addr == own_addr);
        bit  seen   = cmd_valid && run_en && good_par && (to_bc || to_own);
        bit  modec  = (cmd_subaddr == 0) || (cmd_subaddr == 31);
        bit  bad    = illegal_hit || (undef_mc_off && modec && undefined_code(cmd_tr, int'(cmd_wc_mc)));
        e_acc = seen && !bad;
        e_bc  = seen && to_bc;
        e_rsp = seen && to_own;
        e_upd = seen;
        e_pf  = !good_par;
    endtask

    task automatic chk(input string req, input string nm, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "cmd_accept",    cmd_accept,    e_acc);
        chk(req, "cmd_bcast",     cmd_bcast,     e_bc);
        chk(req, "cmd_respond",   cmd_respond,   e_rsp);
        chk(req, "cmd_upd_last",  cmd_upd_last,  e_upd);
        chk(req, "addr_par_fail", addr_par_fail, e_pf);
    endtask

    // Inputs driven at negedge; prediction taken; outputs compared at next negedge
    task automatic step(input string req);
        predict();
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic cmd(input bit v, input int ra, input bit tr, input int sa, input int mc, input bit ill);
        cmd_valid   = v;
        cmd_rt_addr = 5'(ra);
        cmd_tr      = tr;
        cmd_subaddr = 5'(sa);
        cmd_wc_mc   = 5'(mc);
        illegal_hit = ill;
    endtask

    task automatic set_own(input int a, input bit good);
        own_addr     = 5'(a);
        own_addr_par = ~(^own_addr) ^ !good;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        cmd(0, 0, 0, 1, 0, 0);
        set_own(5, 1);
        run_en = 1; bcast_off = 0; undef_mc_off = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "cmd_accept",    cmd_accept,    1'b0);
        chk("R1", "cmd_upd_last",  cmd_upd_last,  1'b0);
        chk("R1", "addr_par_fail", addr_par_fail, 1'b0);
        rst = 1'b0;

        cmd(0, 5, 0, 3, 4, 0); step("R1");        // R1: no strobe -> quiet
        cmd(1, 5, 0, 3, 4, 0); step("R4");        // R4: own address data command
        cmd(1, 9, 1, 3, 4, 0); step("R7");        // R7: foreign address
        cmd(1, 31, 0, 3, 4, 0); step("R5");       // R5: broadcast accepted
        bcast_off = 1;
        cmd(1, 31, 0, 3, 4, 0); step("R6");       // R6: address 31 ignored
        bcast_off = 0;
        run_en = 0;
        cmd(1, 5, 0, 3, 4, 0); step("R2");        // R2: halted
        run_en = 1;
        set_own(5, 0);
        cmd(1, 5, 0, 3, 4, 0); step("R3");        // R3: parity failure blocks
        set_own(5, 1);
        cmd(1, 5, 0, 0, 2, 0); step("R8");        // R8: undefined rx code 2, default allows
        cmd(1, 5, 0, 0, 2, 1); step("R9");        // R9: lookup rules undefined code
        undef_mc_off = 1;
        cmd(1, 5, 0, 31, 18, 0); step("R10");     // R10: rx code 18 illegal
        cmd(1, 5, 1, 0, 20, 0); step("R10");      // R10: tx code 20 illegal
        cmd(1, 5, 1, 0, 18, 0); step("R11");      // R11: defined tx code stays legal
        cmd(1, 5, 0, 0, 17, 0); step("R8");       // R8: rx code 17 is defined
        cmd(1, 5, 0, 7, 2, 0); step("R11");       // R11: data command unaffected
        cmd(1, 5, 1, 7, 2, 1); step("R11");       // R11: lookup illegal
        cmd(1, 31, 0, 0, 5, 0); step("R5");       // R5+R10 same cycle: broadcast undefined
        undef_mc_off = 0;

        for (int i = 0; i < 3000; i++) begin
            int pick = $urandom_range(0, 3);
            int ra   = (pick == 0) ? 31 : (pick == 1) ? int'(own_addr) : $urandom_range(0, 31);
            cmd($urandom_range(0, 3) != 0, ra, 1'($urandom), ($urandom_range(0, 1) != 0) ? 0 : $urandom_range(0, 31),
                $urandom_range(0, 31), $urandom_range(0, 5) == 0);
            if ($urandom_range(0, 15) == 0) set_own($urandom_range(0, 31), $urandom_range(0, 7) != 0);
            run_en       = $urandom_range(0, 9) != 0;
            bcast_off    = 1'($urandom);
            undef_mc_off = 1'($urandom);
            step("R9");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule